// File: doc/BRIEF.md
# Four-Mode Barrel Shifter

This block is a purely combinational shifter for a 32-bit datapath. It moves an operand left or right by a variable distance in one of four ways:

- logical left, with zeros entering at the bottom;
- logical right, with zeros entering at the top;
- arithmetic right, where copies of the sign bit enter at the top;
- rotate right, where bits leaving the bottom re-enter at the top.

It also reports the last bit that left the word, which a flag stage can take as its carry.

The shift distance has two sources, chosen by a select input:

- a 5-bit immediate field, with a reach of 0 to 31;
- the least significant byte of a register operand, with a reach of 0 to 255. The other register bits play no part.

A distance of 32 or more is legal only from the register source, and every mode gives a defined result and carry for it. A distance of zero passes the operand through unchanged. In that case the carry output repeats the incoming carry, so the flag stage sees no change.

Instruction decode, the arithmetic unit and the flag register sit around this block. They are outside it.

Top module: `barrel_shift_unit`

## Requirements
- R1: With `use_reg_i` low the distance is `imm_amt_i` (0..31). With `use_reg_i` high it is `reg_amt_i[7:0]` (0..255), and `reg_amt_i[31:8]` has no effect on either output.
- R2: `kind_i` selects the mode: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R3: For a distance of 0 in any mode, `result_o` equals `opd_i` and `carry_o` equals `carry_i`.
- R4: Logical left by n (1..31) gives `opd_i << n` with zero fill, so a shift by 3 equals multiplying by 8 modulo 2^32. The carry is `opd_i[32-n]`.
- R5: Logical right by n (1..31) gives `opd_i >> n` with zero fill, so a shift by 31 leaves the original bit 31 in bit 0 and zeros above it. The carry is `opd_i[n-1]`.
- R6: Arithmetic right by n (1..31) fills the vacated top bits with `opd_i[31]`. The carry is `opd_i[n-1]`.
- R7: Rotate right by n (nonzero) rotates by n mod 32, and the carry is `opd_i[(n-1) mod 32]`. A nonzero multiple of 32 therefore leaves the value unchanged, with the carry equal to `opd_i[31]`.
- R8: Logical left or logical right by 32 or more gives 0. At exactly 32 the carry is `opd_i[0]` for left and `opd_i[31]` for right. Above 32 the carry is 0.
- R9: Arithmetic right by 32 or more sets every result bit to `opd_i[31]`, and the carry equals `opd_i[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift mode (encoding in R2) |
| imm_amt_i | input | 5 | Immediate shift distance |
| reg_amt_i | input | 32 | Register value; only the low byte is used as the distance |
| use_reg_i | input | 1 | 1: distance from register byte, 0: from immediate |
| carry_i | input | 1 | Current carry, returned unchanged for a zero distance |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Last bit shifted out (or `carry_i` for distance 0) |

## Verification
Each of six operands is swept through every mode, every register distance from 0 to 255 and both incoming carry values. The operands include:

- a lone low bit and a lone high bit, which expose off-by-one errors in the carry index and wrong fill direction;
- all ones, which tells sign fill apart from zero fill;
- irregular mixes, which reveal swapped or misrouted shifter stages.

Because every register distance is used, the boundaries at 0, 31, 32, 33, 64 and 255 are all covered. This separates saturation from modulo wrap-around.

The immediate path is swept separately with junk in the unused register bits. This confirms that the source select and the byte truncation do what R1 states.

// File: rtl/shf_pkg.sv
package shf_pkg;

   // Mode encoding seen on kind_i
   typedef enum logic [1:0] {
      SHF_LSL = 2'd0,
      SHF_LSR = 2'd1,
      SHF_ASR = 2'd2,
      SHF_ROR = 2'd3
   } shf_kind_e;

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 5,
   parameter int REG_AMT_W = 8
) (
   input  logic [IMM_W-1:0]     imm_amt,
   input  logic [REG_AMT_W-1:0] reg_amt,
   input  logic                 use_reg,
   output logic                 is_zero,
   output logic                 ge_width,
   output logic                 eq_width,
   output logic [IMM_W-1:0]     low_amt,
   output logic [IMM_W-1:0]     carry_idx
);

   logic [REG_AMT_W-1:0] amt;

   generate
      if (REG_AMT_W > IMM_W) begin : g_wide
         localparam logic [REG_AMT_W-1:0] WIDTH_AS_AMT = REG_AMT_W'(DATA_W);
         assign amt      = use_reg ? reg_amt : {{(REG_AMT_W-IMM_W){1'b0}}, imm_amt};
         assign ge_width = |amt[REG_AMT_W-1:IMM_W];
         assign eq_width = (amt == WIDTH_AS_AMT);
      end else begin : g_narrow
         assign amt      = use_reg ? reg_amt : imm_amt;
         assign ge_width = 1'b0;
         assign eq_width = 1'b0;
      end
   endgenerate

   assign is_zero   = (amt == '0);
   assign low_amt   = amt[IMM_W-1:0];
   // index of the last bit leaving the word; wraps to DATA_W-1 for multiples of DATA_W
   assign carry_idx = low_amt - IMM_W'(1);

endmodule

// File: rtl/shf_orient.sv
module shf_orient #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic              flip,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] reversed;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_rev
         assign reversed[b] = din[DATA_W-1-b];
      end
   endgenerate

   assign dout = flip ? reversed : din;

endmodule

// File: rtl/shf_right_core.sv
module shf_right_core #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 5
) (
   input  logic [DATA_W-1:0] opd,
   input  logic [IMM_W-1:0]  low_amt,
   input  logic [IMM_W-1:0]  carry_idx,
   input  logic              fill,
   input  logic              rotate,
   output logic [DATA_W-1:0] shifted,
   output logic              last_out
);

   logic [DATA_W-1:0] stg [0:IMM_W];

   assign stg[0] = opd;

   generate
      for (genvar k = 0; k < IMM_W; k++) begin : g_stage
         localparam int STEP = 1 << k;
         logic [STEP-1:0] enter;
         assign enter      = rotate ? stg[k][STEP-1:0] : {STEP{fill}};
         assign stg[k+1]   = low_amt[k] ? {enter, stg[k][DATA_W-1:STEP]} : stg[k];
      end
   endgenerate

   assign shifted  = stg[IMM_W];
   assign last_out = opd[carry_idx];

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8
) (
   input  logic [DATA_W-1:0] opd_i,
   input  logic [1:0]        kind_i,
   input  logic [$clog2(DATA_W)-1:0] imm_amt_i,
   input  logic [DATA_W-1:0] reg_amt_i,
   input  logic              use_reg_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   import shf_pkg::*;

   localparam int IMM_W = $clog2(DATA_W);

   generate
      if (DATA_W != (1 << IMM_W)) begin : g_bad_width
         $fatal(1, "DATA_W must be a power of two");
      end
      if (REG_AMT_W < IMM_W || REG_AMT_W > DATA_W) begin : g_bad_amt
         $fatal(1, "REG_AMT_W must lie between log2(DATA_W) and DATA_W");
      end
   endgenerate

   shf_kind_e kind;
   logic is_zero, ge_width, eq_width;
   logic [IMM_W-1:0] low_amt, carry_idx;
   logic is_left, is_rot, is_arith, sign, fill;
   logic [DATA_W-1:0] fwd, core_out, shifted;
   logic core_carry;

   assign kind     = shf_kind_e'(kind_i);
   assign is_left  = (kind == SHF_LSL);
   assign is_rot   = (kind == SHF_ROR);
   assign is_arith = (kind == SHF_ASR);
   assign sign     = opd_i[DATA_W-1];
   assign fill     = is_arith & sign;

   shf_amount_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W)) u_amt (
      .imm_amt   (imm_amt_i),
      .reg_amt   (reg_amt_i[REG_AMT_W-1:0]),
      .use_reg   (use_reg_i),
      .is_zero   (is_zero),
      .ge_width  (ge_width),
      .eq_width  (eq_width),
      .low_amt   (low_amt),
      .carry_idx (carry_idx)
   );

   // left shifts run through the right shifter on a bit-reversed word
   shf_orient #(.DATA_W(DATA_W)) u_in_orient (
      .din  (opd_i),
      .flip (is_left),
      .dout (fwd)
   );

   shf_right_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
      .opd       (fwd),
      .low_amt   (low_amt),
      .carry_idx (carry_idx),
      .fill      (fill),
      .rotate    (is_rot),
      .shifted   (core_out),
      .last_out  (core_carry)
   );

   shf_orient #(.DATA_W(DATA_W)) u_out_orient (
      .din  (core_out),
      .flip (is_left),
      .dout (shifted)
   );

   always_comb begin
      result_o = shifted;
      carry_o  = core_carry;
      if (is_zero) begin
         result_o = opd_i;
         carry_o  = carry_i;
      end else if (ge_width && !is_rot) begin
         if (is_arith) begin
            result_o = {DATA_W{sign}};
            carry_o  = sign;
         end else begin
            result_o = '0;
            carry_o  = eq_width & fwd[DATA_W-1];
         end
      end
   end

endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8
) (
   input logic [DATA_W-1:0] opd_i,
   input logic [1:0]        kind_i,
   input logic [$clog2(DATA_W)-1:0] imm_amt_i,
   input logic [DATA_W-1:0] reg_amt_i,
   input logic              use_reg_i,
   input logic              carry_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o
);

   int n;
   int r;

   always_comb begin
      n = use_reg_i ? int'(reg_amt_i[REG_AMT_W-1:0]) : int'(imm_amt_i);
      r = n % DATA_W;
      if (!$isunknown({opd_i, kind_i, imm_amt_i, reg_amt_i, use_reg_i, carry_i})) begin
         assert_zero_pass_R3: assert (n != 0 || (result_o == opd_i && carry_o == carry_i))
            else $error("distance 0 did not pass operand and carry");
         assert_left_R4: assert (!(kind_i == 2'd0 && n != 0) || result_o == (opd_i << n))
            else $error("logical left result wrong");
         assert_right_R5: assert (!(kind_i == 2'd1 && n != 0) || result_o == (opd_i >> n))
            else $error("logical right result wrong");
         assert_arith_R6: assert (!(kind_i == 2'd2 && n != 0) ||
                                  result_o == DATA_W'($signed(opd_i) >>> n))
            else $error("arithmetic right result wrong");
         assert_rot_R7: assert (!(kind_i == 2'd3 && n != 0) ||
                                (((result_o << r) | (result_o >> (DATA_W - r))) == opd_i))
            else $error("rotate result is not a rotation of the operand");
         assert_far_carry_R8: assert (!(kind_i[1] == 1'b0 && n > DATA_W) || !carry_o)
            else $error("carry set beyond full logical shift");
      end
   end

endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_chk (
   .opd_i     (opd_i),
   .kind_i    (kind_i),
   .imm_amt_i (imm_amt_i),
   .reg_amt_i (reg_amt_i),
   .use_reg_i (use_reg_i),
   .carry_i   (carry_i),
   .result_o  (result_o),
   .carry_o   (carry_o)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opd_i = '0;
   logic [1:0]  kind_i = '0;
   logic [4:0]  imm_amt_i = '0;
   logic [31:0] reg_amt_i = '0;
   logic        use_reg_i = 1'b0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   barrel_shift_unit u_barrel_shift_unit (
      .opd_i     (opd_i),
      .kind_i    (kind_i),
      .imm_amt_i (imm_amt_i),
      .reg_amt_i (reg_amt_i),
      .use_reg_i (use_reg_i),
      .carry_i   (carry_i),
      .result_o  (result_o),
      .carry_o   (carry_o)
   );

   // bit-by-bit reference model built from the requirement text
   task automatic model(input logic [31:0] v, input logic [1:0] k, input int n,
                        input logic cin, output logic [31:0] r, output logic c);
      r = '0;
      c = 1'b0;
      if (n == 0) begin
         r = v;
         c = cin;
      end else begin
         for (int i = 0; i < 32; i++) begin
            case (k)
               2'd0: r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
               2'd1: r[i] = (i + n < 32) ? v[i+n] : 1'b0;
               2'd2: r[i] = (i + n < 32) ? v[i+n] : v[31];
               default: r[i] = v[(i + n) % 32];
            endcase
         end
         case (k)
            2'd0: c = (n <= 32) ? v[32-n] : 1'b0;
            2'd1: c = (n <= 32) ? v[n-1] : 1'b0;
            2'd2: c = (n <= 32) ? v[n-1] : v[31];
            default: c = v[(n - 1) % 32];
         endcase
      end
   endtask

   function automatic string tag_of(input logic [1:0] k, input int n);
      if (n == 0) return "R3";
      case (k)
         2'd0: return (n >= 32) ? "R8" : "R4";
         2'd1: return (n >= 32) ? "R8" : "R5";
         2'd2: return (n >= 32) ? "R9" : "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic compare(input string tag, input logic [31:0] er, input logic ec);
      checks++;
      if (result_o !== er || carry_o !== ec) begin
         fails++;
         $display("FAIL %s: kind=%0d use_reg=%0d imm=%0d reg=%h opd=%h got res=%h c=%b expected res=%h c=%b",
                  tag, kind_i, use_reg_i, imm_amt_i, reg_amt_i, opd_i, result_o, carry_o, er, ec);
      end
   endtask

   task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic ur,
                        input logic [4:0] imm, input logic [31:0] rg, input logic cin);
      @(posedge clk);
      opd_i = v; kind_i = k; use_reg_i = ur; imm_amt_i = imm; reg_amt_i = rg; carry_i = cin;
      @(negedge clk);
   endtask

   task automatic run_one(input string tag, input logic [31:0] v, input logic [1:0] k,
                          input logic ur, input logic [4:0] imm, input logic [31:0] rg,
                          input logic cin);
      logic [31:0] er;
      logic ec;
      int n;
      n = ur ? int'(rg[7:0]) : int'(imm);
      model(v, k, n, cin, er, ec);
      apply(v, k, ur, imm, rg, cin);
      compare(tag, er, ec);
   endtask

   logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                             32'hC3A5_0F96, 32'h5A5A_1234, 32'h7FFF_FFFE};

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R3: all-zero inputs after reset give a zero result and zero carry
      compare("R3", 32'h0, 1'b0);

      // R4: shift left by 3 multiplies by 8
      run_one("R4", 32'h0000_1357, 2'd0, 1'b0, 5'd3, 32'h0, 1'b0);
      if (result_o !== 32'h0000_1357 * 8) begin
         fails++;
         $display("FAIL R4: x8 got %h expected %h", result_o, 32'h0000_1357 * 8);
      end
      checks++;

      // R5: right by 31 keeps only old bit 31, in bit 0
      run_one("R5", 32'h9000_0000, 2'd1, 1'b0, 5'd31, 32'h0, 1'b0);
      checks++;
      if (result_o !== 32'h1) begin
         fails++;
         $display("FAIL R5: shift 31 got %h expected %h", result_o, 32'h1);
      end

      // R2: one fixed vector per encoding, distance 4
      for (int k = 0; k < 4; k++)
         run_one("R2", 32'h8123_4567, 2'(k), 1'b0, 5'd4, 32'h0, 1'b1);

      // R7: multiple of 32 from the register leaves the value, carry = bit 31
      run_one("R7", 32'h8765_4320, 2'd3, 1'b1, 5'd0, 32'h0000_0040, 1'b0);

      // R1: immediate sweep with junk in the register input; register byte with junk above it
      foreach (pats[p])
         for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a++) begin
               run_one("R1", pats[p], 2'(k), 1'b0, 5'(a), ~pats[p], 1'b1);
               run_one("R1", pats[p], 2'(k), 1'b1, ~5'(a), {~pats[p][31:8], 8'(a)}, 1'b0);
            end

      // full register-distance sweep: R3..R9 tagged per case
      foreach (pats[p])
         for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
               for (int ci = 0; ci < 2; ci++)
                  run_one(tag_of(2'(k), a), pats[p], 2'(k), 1'b1, 5'(a * 7),
                          {pats[p][23:0], 8'(a)}, 1'(ci));

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule